// File: doc/BRIEF.md
# RAM-Based Ternary Match Array

This block is a ternary content-addressable memory whose matching is done by table lookup rather than by one comparator per entry. The search key is cut into 7-bit slices. Every slice owns a 128-word RAM, and each word holds one bit per entry. Bit e of word v is set when entry e accepts the value v in that slice position. A search reads all slice RAMs in parallel at the addresses given by the key slices. The block ANDs the words it reads into a vector with one match line per entry. Any number of those lines may be high at once.

An entry is stored from an index, a data word and a care mask of the same width. A care bit of 0 makes that key bit irrelevant for the entry. The don't-care expansion is done when the entry is stored: a sequencer walks all 128 slice values and rewrites the entry's bit in every slice RAM. A store therefore takes 128 cycles, and `ready` is low while it runs. After reset the same sequencer clears every RAM word, so that no entry matches, and then raises `ready`. Once the block is idle, a new key may be presented on every clock. Its match vector appears two cycles later.

Top module: `ram_tcam`

## Requirements
- R1: While reset is asserted, and afterwards until initialisation completes, `ready` is low. It rises on the 128th rising clock edge after reset is released. After that, every key produces an all-zero match vector until an entry is stored.
- R2: A `start_write` pulse sampled while `ready` is high starts a store. `ready` is low from the next cycle for exactly 128 cycles and then returns high.
- R3: A `start_write` sampled while `ready` is low is ignored. It neither stores its entry nor lengthens the store already in progress.
- R4: An entry stored with all care bits 1 matches only the key equal to its data word. A key that differs from it in any single bit leaves that entry's line low.
- R5: A key bit whose care bit is 0 has no effect on that entry's match, in any slice. An entry with an all-zero care mask matches every key.
- R6: When several entries accept a key, all of their match lines are high in the same result. Bit e of `match` belongs to the entry stored at index e.
- R7: When no stored entry accepts a key, `match` is all zeros.
- R8: With `ready` high, the match vector for a key applied before rising edge k is on `match` after rising edge k+1. Keys may change every cycle, and each result belongs only to its own key.
- R9: Storing to an index that already holds an entry replaces it completely. The old pattern no longer matches at that index unless the new pattern accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_write | input | 1 | One-cycle pulse that starts a store while ready is high |
| wr_index | input | ADDR_WIDTH | Entry index to store |
| wr_data | input | 7*SLICES | Data pattern of the entry |
| wr_care | input | 7*SLICES | Care mask, 1 = bit compared, 0 = bit ignored |
| ready | output | 1 | High when idle, low during initialisation or a store |
| key | input | 7*SLICES | Search key, may change every cycle |
| match | output | 2**ADDR_WIDTH | One match line per entry, two cycles after the key |

## Verification
The bench builds the block with its default values: five slices, giving a 35-bit key, and an index width of 5, giving 32 entries. At that size the highest entry index (31) and masks that clear bits in both the lowest and the highest slice can be exercised, along with keys that differ from an entry only in its top slice. The full 128-step store and clear sequences also run at their real length, so `ready` timing is checked cycle-exact at the default depth.

// File: rtl/tcam_pkg.sv
// Package: shared constants and the sequencer state type for the
// RAM-based ternary match array. Assumes a fixed 7-bit slice width.
package tcam_pkg;
    localparam int SLICE_BITS  = 7;
    localparam int SLICE_DEPTH = 1 << SLICE_BITS;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tcam_slice_ram.sv
// Module: one slice RAM. It has SLICE_DEPTH words of ENTRIES bits, a
// bit-masked write port and a registered read port.
// Assumes: a read at the address being written returns the old word.
module tcam_slice_ram #(
    parameter int ENTRIES = 32
) (
    input  logic                                 clk,
    input  logic                                 wr_en,
    input  logic [tcam_pkg::SLICE_BITS-1:0]      wr_addr,
    input  logic [ENTRIES-1:0]                   wr_mask,
    input  logic                                 wr_val,
    input  logic [tcam_pkg::SLICE_BITS-1:0]      rd_addr,
    output logic [ENTRIES-1:0]                   rd_data
);
    logic [ENTRIES-1:0] mem [tcam_pkg::SLICE_DEPTH];

    // Updates the masked bits of one word with the write value.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= (mem[wr_addr] & ~wr_mask) | (wr_mask & {ENTRIES{wr_val}});
        end
    end

    // Registers the word selected by the key slice.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/tcam_write_seq.sv
// Module: store and initialisation sequencer. After reset it steps through
// all slice values and clears every word. An accepted store latches index,
// data and care mask, then steps through all slice values again. At each
// step it writes, for every slice, whether that value is accepted.
// Assumes: start_write is ignored unless the sequencer is idle.
module tcam_write_seq #(
    parameter int SLICES     = 5,
    parameter int ADDR_WIDTH = 5,
    localparam int KEY_W     = SLICES * tcam_pkg::SLICE_BITS,
    localparam int ENTRIES   = 1 << ADDR_WIDTH
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_write,
    input  logic [ADDR_WIDTH-1:0]            wr_index,
    input  logic [KEY_W-1:0]                 wr_data,
    input  logic [KEY_W-1:0]                 wr_care,
    output logic                             ready,
    output logic                             ram_we,
    output logic [tcam_pkg::SLICE_BITS-1:0]  ram_addr,
    output logic [ENTRIES-1:0]               ram_mask,
    output logic [SLICES-1:0]                ram_bits
);
    import tcam_pkg::*;

    seq_state_t            state;
    logic [SLICE_BITS-1:0] step;
    logic [ADDR_WIDTH-1:0] idx_q;
    logic [KEY_W-1:0]      data_q;
    logic [KEY_W-1:0]      care_q;

    // Advances the state and the step counter, and latches a store request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_INIT;
            step   <= '0;
            idx_q  <= '0;
            data_q <= '0;
            care_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_write) begin
                        state  <= ST_WRITE;
                        step   <= '0;
                        idx_q  <= wr_index;
                        data_q <= wr_data;
                        care_q <= wr_care;
                    end
                end
                ST_INIT, ST_WRITE: begin
                    step <= step + 1'b1;
                    if (step == SLICE_BITS'(SLICE_DEPTH - 1)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_INIT;
            endcase
        end
    end

    // Drives the shared RAM write controls from the state.
    always_comb begin
        ready    = (state == ST_IDLE);
        ram_we   = (state != ST_IDLE);
        ram_addr = step;
        ram_mask = (state == ST_INIT) ? '1 : (ENTRIES'(1) << idx_q);
    end

    // Computes, per slice, whether the current step value is accepted.
    for (genvar s = 0; s < SLICES; s++) begin : g_bit
        always_comb begin
            ram_bits[s] = (state == ST_WRITE) &&
                (((step ^ data_q[s*SLICE_BITS +: SLICE_BITS]) &
                  care_q[s*SLICE_BITS +: SLICE_BITS]) == '0);
        end
    end
endmodule

// File: rtl/ram_tcam.sv
// Module: top of the RAM-based ternary match array. Each key slice
// addresses its own slice RAM. The registered words are ANDed together and
// registered again, giving the match vector two cycles after the key.
// Assumes: results are only meaningful while ready is high.
module ram_tcam #(
    parameter int SLICES     = 5,
    parameter int ADDR_WIDTH = 5,
    localparam int KEY_W     = SLICES * tcam_pkg::SLICE_BITS,
    localparam int ENTRIES   = 1 << ADDR_WIDTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_write,
    input  logic [ADDR_WIDTH-1:0]  wr_index,
    input  logic [KEY_W-1:0]       wr_data,
    input  logic [KEY_W-1:0]       wr_care,
    output logic                   ready,
    input  logic [KEY_W-1:0]       key,
    output logic [ENTRIES-1:0]     match
);
    import tcam_pkg::*;

    logic                  ram_we;
    logic [SLICE_BITS-1:0] ram_addr;
    logic [ENTRIES-1:0]    ram_mask;
    logic [SLICES-1:0]     ram_bits;
    logic [ENTRIES-1:0]    rd_word [SLICES];
    logic [ENTRIES-1:0]    and_all;

    tcam_write_seq #(
        .SLICES     (SLICES),
        .ADDR_WIDTH (ADDR_WIDTH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_write (start_write),
        .wr_index    (wr_index),
        .wr_data     (wr_data),
        .wr_care     (wr_care),
        .ready       (ready),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_mask    (ram_mask),
        .ram_bits    (ram_bits)
    );

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        tcam_slice_ram #(
            .ENTRIES (ENTRIES)
        ) u_ram (
            .clk     (clk),
            .wr_en   (ram_we),
            .wr_addr (ram_addr),
            .wr_mask (ram_mask),
            .wr_val  (ram_bits[s]),
            .rd_addr (key[s*SLICE_BITS +: SLICE_BITS]),
            .rd_data (rd_word[s])
        );
    end

    // Combines the per-slice words into one vector of candidate matches.
    always_comb begin
        and_all = '1;
        for (int s = 0; s < SLICES; s++) begin
            and_all = and_all & rd_word[s];
        end
    end

    // Registers the combined vector as the match output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match <= '0;
        end else begin
            match <= and_all;
        end
    end
endmodule

// File: rtl/tcam_checker.sv
// Module: property checker for ram_tcam. It watches ready timing, ignored
// store requests and the stability of the lookup pipeline.
module tcam_checker #(
    parameter int KEY_W   = 35,
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_write,
    input logic               ready,
    input logic [KEY_W-1:0]   key,
    input logic [ENTRIES-1:0] match
);
    logic [8:0]       busy_cnt;
    logic [KEY_W-1:0] k1, k2, k3;
    logic             r1, r2, r3, r4;

    // Counts consecutive cycles with ready low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             busy_cnt <= '0;
        else if (ready)         busy_cnt <= '0;
        else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
    end

    // Keeps a short history of the key and ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k1 <= '0; k2 <= '0; k3 <= '0;
            r1 <= 1'b0; r2 <= 1'b0; r3 <= 1'b0; r4 <= 1'b0;
        end else begin
            k1 <= key; k2 <= k1; k3 <= k2;
            r1 <= ready; r2 <= r1; r3 <= r2; r4 <= r3;
        end
    end

    // R2: an accepted store drops ready in the next cycle.
    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start_write) |=> !ready);

    // R1 and R2: ready returns only after exactly 128 low cycles.
    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_cnt == 9'd128));

    // R3: a request while busy does not end or restart the store.
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start_write && busy_cnt < 9'd127) |=> !ready);

    // R8: a repeated key while idle gives the same result again.
    p_lookup_pipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && r1 && r2 && r3 && r4 && (k2 == k3)) |-> (match == $past(match)));
endmodule

bind ram_tcam tcam_checker #(
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_write (start_write),
    .ready       (ready),
    .key         (key),
    .match       (match)
);

// File: tb/sim_ram_tcam.sv
// Bench: directed scenarios for ram_tcam, checked against a reference model
// of stored patterns kept in the bench.
module sim_ram_tcam;
    localparam int CLK_PERIOD = 10;
    localparam int SLICES     = 5;
    localparam int ADDR_WIDTH = 5;
    localparam int KEY_W      = SLICES * 7;
    localparam int ENTRIES    = 1 << ADDR_WIDTH;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_write = 1'b0;
    logic [ADDR_WIDTH-1:0] wr_index = '0;
    logic [KEY_W-1:0]      wr_data = '0;
    logic [KEY_W-1:0]      wr_care = '0;
    logic                  ready;
    logic [KEY_W-1:0]      key = '0;
    logic [ENTRIES-1:0]    match;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [KEY_W-1:0] m_data [ENTRIES];
    logic [KEY_W-1:0] m_care [ENTRIES];
    logic             m_used [ENTRIES];

    ram_tcam #(.SLICES(SLICES), .ADDR_WIDTH(ADDR_WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start_write(start_write),
        .wr_index(wr_index), .wr_data(wr_data), .wr_care(wr_care),
        .ready(ready), .key(key), .match(match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [ENTRIES-1:0] model(input logic [KEY_W-1:0] k);
        logic [ENTRIES-1:0] v = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (m_used[e] && (((k ^ m_data[e]) & m_care[e]) == '0)) v[e] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [KEY_W-1:0] k);
        @(negedge clk); key = k;
        @(negedge clk);
        @(negedge clk);
        check(req, 64'(match), 64'(model(k)));
    endtask

    task automatic store(input logic [ADDR_WIDTH-1:0] a, input logic [KEY_W-1:0] d,
                         input logic [KEY_W-1:0] c);
        int lows = 0;
        @(negedge clk);
        wr_index = a; wr_data = d; wr_care = c; start_write = 1'b1;
        @(negedge clk);
        start_write = 1'b0;
        check("R2 ready low after start", 64'(ready), 64'd0);
        while (!ready && lows < 400) begin
            lows++;
            @(negedge clk);
        end
        check("R2 busy length", 64'(lows), 64'd128);
        m_data[a] = d; m_care[a] = c; m_used[a] = 1'b1;
    endtask

    task automatic t_reset();
        int edges = 0;
        for (int e = 0; e < ENTRIES; e++) m_used[e] = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 64'(ready), 64'd0);
        rst_n = 1'b1;
        while (!ready && edges < 400) begin
            @(negedge clk);
            edges++;
        end
        check("R1 init length", 64'(edges), 64'd128);
        lookup("R1 empty after init a", 35'h0);
        lookup("R1 empty after init b", 35'h7_ffff_ffff);
        lookup("R1 empty after init c", 35'h2_5a5a_1234);
    endtask

    task automatic t_exact();
        store(7, 35'h0_0105_0aff, '1);
        lookup("R4 exact hit", 35'h0_0105_0aff);
        lookup("R4 low bit differs", 35'h0_0105_0afe);
        lookup("R4 top slice differs", 35'h4_0105_0aff);
        check("R4 exact hit index", 64'(model(35'h0_0105_0aff)), 64'h80);
    endtask

    task automatic t_masked();
        store(0,  35'h0_e3d2_1200, 35'h7_ffff_ff00);
        store(5,  35'h0_13d2_0000, 35'h7_ffff_0000);
        store(31, 35'h0_13d2_0100, 35'h7_ffff_ff00);
        store(20, 35'h4_0000_0033, 35'h3_ffff_ffff);
        lookup("R5 low byte ignored", 35'h0_e3d2_12c7);
        lookup("R6 two entries hit", 35'h0_13d2_0134);
        lookup("R6 one entry of pair", 35'h0_13d2_1234);
        lookup("R5 top bit ignored", 35'h0_0000_0033);
        lookup("R7 no entry hits", 35'h0_f3d2_1212);
        check("R6 pair lines", 64'(model(35'h0_13d2_0134)), 64'h8000_0020);
    endtask

    task automatic t_pipe();
        logic [KEY_W-1:0] ks [6];
        ks[0] = 35'h0_0105_0aff; ks[1] = 35'h0_13d2_1234; ks[2] = 35'h0_13d2_0134;
        ks[3] = 35'h0_f3d2_1212; ks[4] = 35'h0_e3d2_1212; ks[5] = 35'h4_0000_0033;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 2) check("R8 back-to-back result", 64'(match), 64'(model(ks[i-2])));
            if (i < 6) key = ks[i];
        end
    endtask

    task automatic t_ignored();
        int lows = 0;
        @(negedge clk);
        wr_index = 9; wr_data = 35'h1_2345_6789; wr_care = '1; start_write = 1'b1;
        @(negedge clk);
        start_write = 1'b0;
        repeat (40) begin @(negedge clk); lows++; end
        wr_index = 12; wr_data = 35'h5_5555_5555; wr_care = '1; start_write = 1'b1;
        @(negedge clk); lows++;
        start_write = 1'b0;
        while (!ready && lows < 400) begin @(negedge clk); lows++; end
        check("R3 store not extended", 64'(lows), 64'd128);
        m_data[9] = 35'h1_2345_6789; m_care[9] = '1; m_used[9] = 1'b1;
        lookup("R3 ignored entry absent", 35'h5_5555_5555);
        lookup("R3 accepted entry present", 35'h1_2345_6789);
    endtask

    task automatic t_replace();
        store(5, 35'h2_0000_0abc, '1);
        lookup("R9 old pattern gone", 35'h0_13d2_0000);
        lookup("R9 new pattern hits", 35'h2_0000_0abc);
        store(14, '0, '0);
        lookup("R5 all don't-care entry", 35'h6_dead_beef);
        lookup("R5 all don't-care with others", 35'h0_0105_0aff);
    endtask

    initial begin
        t_reset();
        t_exact();
        t_masked();
        t_pipe();
        t_ignored();
        t_replace();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule